// File: doc/BRIEF.md
# Capture Channel Control Register Bank

This block holds the software-visible control and status words for a group of input-capture channels. It sits behind a simple word-addressed register bus. A write carries a per-bit write-enable mask in its upper half and the new values in its lower half. Bit 16+n of the write word decides whether bit n changes. Software can therefore set or clear one field without first reading the word back. The stored fields drive the capture logic through registered outputs, and the capture logic reports its state back through status inputs.

Each channel takes seven consecutive word addresses, and the channels are packed one after another from address 0. Two fields are clear commands rather than stored values: an interrupt clear and a FIFO clear. Writing 1 to one of them gives a one-cycle pulse to the capture logic, and the field always reads back as 0. Reserved bits, the mask half of every word, and every word above the last channel read as zero and ignore writes.

Top module: `capture_ctrl_regs`

## Requirements
- R1: A write to a stored field changes bit n (n in 0..15) only when bit 16+n of the write word is 1. Every other stored bit keeps its value, so writing 0x00010001 to a channel's word 0 sets only its enable.
- R2: Bits 31:16 of every read return 0. Mask bits are not stored.
- R3: After a synchronous reset, every stored field, every strobe and `bus_rdata` are 0.
- R4: Word 0 of channel c (address 7c) holds enable at bit 0, source select at bits 5:3 and clock select at bits 8:6. Bit 2 is the interrupt clear: writing 1 to it with bit 18 set raises `irq_clr[c]` for exactly the one cycle after the write, and bit 2 reads as 0.
- R5: Word 1 (address 7c+1) holds edge mode at bits 1:0, event threshold at 5:2 and debounce setting at 8:6. Bit 13 is the FIFO clear: writing 1 to it with bit 29 set gives a one-cycle pulse on `fifo_clr[c]`. Writing 0 to it, or writing 1 without the mask bit, gives no pulse. It reads as 0.
- R6: Word 1 bits 15, 14 and 12 read the channel's FIFO full, FIFO empty and data-dropped inputs. Words 4, 5 and 6 read the event count, high width and low width inputs. Writes to these bits never change what they read.
- R7: Words 2 and 3 are 16-bit stored values (counter prescale and test scale), each driven on its output and updated under R1.
- R8: Reserved bits read as 0 and ignore writes: word 0 bits 1 and 15:9, and word 1 bits 11:9.
- R9: Addresses at or above 7*NUM_CH read as 0. Writes to them change no output.
- R10: A read returns its word on `bus_rdata` after the next clock edge. `bus_rdata` holds its value in cycles without a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write request |
| bus_rd | input | 1 | Read request |
| bus_addr | input | ADDR_W | Word address |
| bus_wdata | input | 32 | Mask (31:16) and data (15:0) |
| bus_rdata | output | 32 | Registered read data |
| ch_en | output | NUM_CH | Channel enable |
| ch_clk_sel | output | 3*NUM_CH | Clock source select per channel |
| ch_src_sel | output | 3*NUM_CH | Input source select per channel |
| ch_edge_mode | output | 2*NUM_CH | Edge detect mode per channel |
| ch_thresh | output | 4*NUM_CH | Event threshold per channel |
| ch_debounce | output | 3*NUM_CH | Debounce setting per channel |
| ch_prescale | output | 16*NUM_CH | Counter prescale per channel |
| ch_test_scale | output | 16*NUM_CH | Test signal scale per channel |
| irq_clr | output | NUM_CH | One-cycle interrupt clear pulse |
| fifo_clr | output | NUM_CH | One-cycle FIFO clear pulse |
| st_full | input | NUM_CH | FIFO full status |
| st_empty | input | NUM_CH | FIFO empty status |
| st_drop | input | NUM_CH | Data dropped status |
| st_count | input | 16*NUM_CH | Event count status |
| st_high | input | 16*NUM_CH | High pulse width status |
| st_low | input | 16*NUM_CH | Low pulse width status |

## Verification
The bench builds the block with NUM_CH=4 and ADDR_W=5. The 32-word address space then holds 28 channel words and exactly four unmapped words at the top, so random addresses reach every channel word, every channel boundary and the zero-reading region. With four channels, the bench can check that a strobe or a masked write on one channel leaves the three neighbours unchanged.

// File: rtl/capreg_pkg.sv
package capreg_pkg;
  localparam int HALF_W = 16;
  localparam int WORDS_PER_CH = 7;

  localparam int W_CTRL  = 0;
  localparam int W_FILT  = 1;
  localparam int W_PRE   = 2;
  localparam int W_TST   = 3;
  localparam int W_COUNT = 4;
  localparam int W_HIGH  = 5;
  localparam int W_LOW   = 6;

  localparam int SRC_W  = 3;
  localparam int CLK_W  = 3;
  localparam int MODE_W = 2;
  localparam int THR_W  = 4;
  localparam int DEB_W  = 3;

  localparam int CTL_EN     = 0;
  localparam int CTL_IRQ    = 2;
  localparam int CTL_SRC_LO = 3;
  localparam int CTL_CLK_LO = 6;

  localparam int FLT_MODE_LO = 0;
  localparam int FLT_THR_LO  = 2;
  localparam int FLT_DEB_LO  = 6;
  localparam int FLT_DROP    = 12;
  localparam int FLT_CLR     = 13;
  localparam int FLT_EMPTY   = 14;
  localparam int FLT_FULL    = 15;
endpackage

// File: rtl/capreg_field.sv
module capreg_field #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         we,
  input  logic [W-1:0] d,
  input  logic [W-1:0] m,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)
      q <= '0;
    else if (we)
      q <= (q & ~m) | (d & m);
  end
endmodule

// File: rtl/capreg_strobe.sv
module capreg_strobe (
  input  logic clk,
  input  logic rst,
  input  logic fire,
  output logic pulse
);
  always_ff @(posedge clk) begin
    if (rst)
      pulse <= 1'b0;
    else
      pulse <= fire;
  end
endmodule

// File: rtl/capreg_chan.sv
module capreg_chan
  import capreg_pkg::*;
#(
  parameter int HW = HALF_W
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [WORDS_PER_CH-1:0]       wsel,
  input  logic [HW-1:0]                 wval,
  input  logic [HW-1:0]                 wmsk,
  input  logic                          st_full,
  input  logic                          st_empty,
  input  logic                          st_drop,
  input  logic [HW-1:0]                 st_count,
  input  logic [HW-1:0]                 st_high,
  input  logic [HW-1:0]                 st_low,
  output logic                          en,
  output logic [CLK_W-1:0]              clk_sel,
  output logic [SRC_W-1:0]              src_sel,
  output logic [MODE_W-1:0]             edge_mode,
  output logic [THR_W-1:0]              thresh,
  output logic [DEB_W-1:0]              debounce,
  output logic [HW-1:0]                 prescale,
  output logic [HW-1:0]                 test_scale,
  output logic                          irq_clr,
  output logic                          fifo_clr,
  output logic [WORDS_PER_CH-1:0][HW-1:0] rd_words
);
  // control word
  capreg_field #(.W(1)) u_en (
    .clk(clk), .rst(rst), .we(wsel[W_CTRL]),
    .d(wval[CTL_EN]), .m(wmsk[CTL_EN]), .q(en));

  capreg_field #(.W(SRC_W)) u_src (
    .clk(clk), .rst(rst), .we(wsel[W_CTRL]),
    .d(wval[CTL_SRC_LO +: SRC_W]), .m(wmsk[CTL_SRC_LO +: SRC_W]), .q(src_sel));

  capreg_field #(.W(CLK_W)) u_clk (
    .clk(clk), .rst(rst), .we(wsel[W_CTRL]),
    .d(wval[CTL_CLK_LO +: CLK_W]), .m(wmsk[CTL_CLK_LO +: CLK_W]), .q(clk_sel));

  capreg_strobe u_irq (
    .clk(clk), .rst(rst),
    .fire(wsel[W_CTRL] & wmsk[CTL_IRQ] & wval[CTL_IRQ]),
    .pulse(irq_clr));

  // filter word
  capreg_field #(.W(MODE_W)) u_mode (
    .clk(clk), .rst(rst), .we(wsel[W_FILT]),
    .d(wval[FLT_MODE_LO +: MODE_W]), .m(wmsk[FLT_MODE_LO +: MODE_W]), .q(edge_mode));

  capreg_field #(.W(THR_W)) u_thr (
    .clk(clk), .rst(rst), .we(wsel[W_FILT]),
    .d(wval[FLT_THR_LO +: THR_W]), .m(wmsk[FLT_THR_LO +: THR_W]), .q(thresh));

  capreg_field #(.W(DEB_W)) u_deb (
    .clk(clk), .rst(rst), .we(wsel[W_FILT]),
    .d(wval[FLT_DEB_LO +: DEB_W]), .m(wmsk[FLT_DEB_LO +: DEB_W]), .q(debounce));

  capreg_strobe u_fclr (
    .clk(clk), .rst(rst),
    .fire(wsel[W_FILT] & wmsk[FLT_CLR] & wval[FLT_CLR]),
    .pulse(fifo_clr));

  // full-width stored words
  capreg_field #(.W(HW)) u_pre (
    .clk(clk), .rst(rst), .we(wsel[W_PRE]),
    .d(wval), .m(wmsk), .q(prescale));

  capreg_field #(.W(HW)) u_tst (
    .clk(clk), .rst(rst), .we(wsel[W_TST]),
    .d(wval), .m(wmsk), .q(test_scale));

  // read view; strobes and reserved bits stay zero
  always_comb begin
    rd_words = '0;
    rd_words[W_CTRL][CTL_EN]                  = en;
    rd_words[W_CTRL][CTL_SRC_LO +: SRC_W]     = src_sel;
    rd_words[W_CTRL][CTL_CLK_LO +: CLK_W]     = clk_sel;
    rd_words[W_FILT][FLT_MODE_LO +: MODE_W]   = edge_mode;
    rd_words[W_FILT][FLT_THR_LO +: THR_W]     = thresh;
    rd_words[W_FILT][FLT_DEB_LO +: DEB_W]     = debounce;
    rd_words[W_FILT][FLT_DROP]                = st_drop;
    rd_words[W_FILT][FLT_EMPTY]               = st_empty;
    rd_words[W_FILT][FLT_FULL]                = st_full;
    rd_words[W_PRE]                           = prescale;
    rd_words[W_TST]                           = test_scale;
    rd_words[W_COUNT]                         = st_count;
    rd_words[W_HIGH]                          = st_high;
    rd_words[W_LOW]                           = st_low;
  end
endmodule

// File: rtl/capture_ctrl_regs.sv
module capture_ctrl_regs
  import capreg_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int ADDR_W = 5
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   bus_wr,
  input  logic                   bus_rd,
  input  logic [ADDR_W-1:0]      bus_addr,
  input  logic [31:0]            bus_wdata,
  output logic [31:0]            bus_rdata,
  output logic [NUM_CH-1:0]        ch_en,
  output logic [NUM_CH*CLK_W-1:0]  ch_clk_sel,
  output logic [NUM_CH*SRC_W-1:0]  ch_src_sel,
  output logic [NUM_CH*MODE_W-1:0] ch_edge_mode,
  output logic [NUM_CH*THR_W-1:0]  ch_thresh,
  output logic [NUM_CH*DEB_W-1:0]  ch_debounce,
  output logic [NUM_CH*HALF_W-1:0] ch_prescale,
  output logic [NUM_CH*HALF_W-1:0] ch_test_scale,
  output logic [NUM_CH-1:0]        irq_clr,
  output logic [NUM_CH-1:0]        fifo_clr,
  input  logic [NUM_CH-1:0]        st_full,
  input  logic [NUM_CH-1:0]        st_empty,
  input  logic [NUM_CH-1:0]        st_drop,
  input  logic [NUM_CH*HALF_W-1:0] st_count,
  input  logic [NUM_CH*HALF_W-1:0] st_high,
  input  logic [NUM_CH*HALF_W-1:0] st_low
);
  localparam int MAPPED = NUM_CH * WORDS_PER_CH;

  logic [HALF_W-1:0] wval, wmsk;
  assign wval = bus_wdata[HALF_W-1:0];
  assign wmsk = bus_wdata[2*HALF_W-1:HALF_W];

  logic [NUM_CH-1:0][WORDS_PER_CH-1:0][HALF_W-1:0] ch_words;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic [WORDS_PER_CH-1:0] wsel;
    for (genvar k = 0; k < WORDS_PER_CH; k++) begin : g_sel
      assign wsel[k] = bus_wr && (int'(bus_addr) == c*WORDS_PER_CH + k);
    end

    capreg_chan #(.HW(HALF_W)) u_chan (
      .clk        (clk),
      .rst        (rst),
      .wsel       (wsel),
      .wval       (wval),
      .wmsk       (wmsk),
      .st_full    (st_full[c]),
      .st_empty   (st_empty[c]),
      .st_drop    (st_drop[c]),
      .st_count   (st_count[c*HALF_W +: HALF_W]),
      .st_high    (st_high[c*HALF_W +: HALF_W]),
      .st_low     (st_low[c*HALF_W +: HALF_W]),
      .en         (ch_en[c]),
      .clk_sel    (ch_clk_sel[c*CLK_W +: CLK_W]),
      .src_sel    (ch_src_sel[c*SRC_W +: SRC_W]),
      .edge_mode  (ch_edge_mode[c*MODE_W +: MODE_W]),
      .thresh     (ch_thresh[c*THR_W +: THR_W]),
      .debounce   (ch_debounce[c*DEB_W +: DEB_W]),
      .prescale   (ch_prescale[c*HALF_W +: HALF_W]),
      .test_scale (ch_test_scale[c*HALF_W +: HALF_W]),
      .irq_clr    (irq_clr[c]),
      .fifo_clr   (fifo_clr[c]),
      .rd_words   (ch_words[c])
    );
  end

  logic [HALF_W-1:0] rd_sel;
  always_comb begin
    rd_sel = '0;
    for (int c = 0; c < NUM_CH; c++)
      for (int k = 0; k < WORDS_PER_CH; k++)
        if (int'(bus_addr) == c*WORDS_PER_CH + k)
          rd_sel = ch_words[c][k];
    if (int'(bus_addr) >= MAPPED)
      rd_sel = '0;
  end

  always_ff @(posedge clk) begin
    if (rst)
      bus_rdata <= '0;
    else if (bus_rd)
      bus_rdata <= {{HALF_W{1'b0}}, rd_sel};
  end
endmodule

// File: rtl/capture_regs_chk.sv
module capture_regs_chk #(
  parameter int NUM_CH = 4,
  parameter int ADDR_W = 5
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_wdata,
  input logic [31:0]       bus_rdata,
  input logic [NUM_CH-1:0] ch_en,
  input logic [NUM_CH-1:0] irq_clr,
  input logic [NUM_CH-1:0] fifo_clr
);
  initial begin
    p_map_fits_r9: assert (NUM_CH * 7 <= 2 ** ADDR_W);
  end

  // R2: mask half never read back
  p_upper_zero_r2: assert property (@(posedge clk) disable iff (rst)
    bus_rdata[31:16] == 16'h0);

  // R10: read data held without a read
  p_rdata_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> $stable(bus_rdata));

  for (genvar c = 0; c < NUM_CH; c++) begin : g_c
    // R4: interrupt clear pulse only after a masked write of 1
    p_irq_src_r4: assert property (@(posedge clk) disable iff (rst)
      irq_clr[c] |-> $past(bus_wr && (int'(bus_addr) == c*7)
                           && bus_wdata[18] && bus_wdata[2]));

    // R5: FIFO clear pulse only after a masked write of 1
    p_fifo_src_r5: assert property (@(posedge clk) disable iff (rst)
      fifo_clr[c] |-> $past(bus_wr && (int'(bus_addr) == c*7 + 1)
                            && bus_wdata[29] && bus_wdata[13]));

    // R1: enable holds unless its own mask bit is written
    p_mask_hold_r1: assert property (@(posedge clk) disable iff (rst)
      !(bus_wr && (int'(bus_addr) == c*7) && bus_wdata[16])
      |=> $stable(ch_en[c]));
  end
endmodule

bind capture_ctrl_regs capture_regs_chk #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .ch_en(ch_en), .irq_clr(irq_clr), .fifo_clr(fifo_clr));

// File: tb/test_capture_ctrl_regs.sv
`timescale 1ns/1ps
module test_capture_ctrl_regs;
  localparam int NC = 4;
  localparam int AW = 5;

  logic clk = 1'b0;
  logic rst;
  logic bus_wr, bus_rd;
  logic [AW-1:0] bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic [NC-1:0] ch_en, irq_clr, fifo_clr;
  logic [NC*3-1:0] ch_clk_sel, ch_src_sel, ch_debounce;
  logic [NC*2-1:0] ch_edge_mode;
  logic [NC*4-1:0] ch_thresh;
  logic [NC*16-1:0] ch_prescale, ch_test_scale;
  logic [NC-1:0] st_full, st_empty, st_drop;
  logic [NC*16-1:0] st_count, st_high, st_low;

  always #2 clk = ~clk;

  capture_ctrl_regs #(.NUM_CH(NC), .ADDR_W(AW)) i_capture_ctrl_regs (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ch_en(ch_en), .ch_clk_sel(ch_clk_sel), .ch_src_sel(ch_src_sel),
    .ch_edge_mode(ch_edge_mode), .ch_thresh(ch_thresh),
    .ch_debounce(ch_debounce), .ch_prescale(ch_prescale),
    .ch_test_scale(ch_test_scale), .irq_clr(irq_clr), .fifo_clr(fifo_clr),
    .st_full(st_full), .st_empty(st_empty), .st_drop(st_drop),
    .st_count(st_count), .st_high(st_high), .st_low(st_low));

  int n_chk = 0;
  int n_err = 0;
  bit done = 0;

  // bench model of stored words (only writable bits kept)
  logic [15:0] m_ctrl [NC];
  logic [15:0] m_filt [NC];
  logic [15:0] m_pre  [NC];
  logic [15:0] m_tst  [NC];
  localparam logic [15:0] CTRL_RW = 16'h01F9;
  localparam logic [15:0] FILT_RW = 16'h01FF;

  task automatic chk(input logic [255:0] act, input logic [255:0] exp, input string req);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] merge(input logic [15:0] old, input logic [31:0] w,
                                        input logic [15:0] rw);
    logic [15:0] m;
    m = w[31:16] & rw;
    return (old & ~m) | (w[15:0] & m);
  endfunction

  task automatic model_write(input int a, input logic [31:0] w);
    int c, k;
    if (a >= NC*7) return;
    c = a / 7; k = a % 7;
    case (k)
      0: m_ctrl[c] = merge(m_ctrl[c], w, CTRL_RW);
      1: m_filt[c] = merge(m_filt[c], w, FILT_RW);
      2: m_pre[c]  = merge(m_pre[c], w, 16'hFFFF);
      3: m_tst[c]  = merge(m_tst[c], w, 16'hFFFF);
      default: ;
    endcase
  endtask

  function automatic logic [31:0] exp_word(input int a);
    int c, k;
    logic [15:0] v;
    if (a >= NC*7) return 32'h0;
    c = a / 7; k = a % 7;
    case (k)
      0: v = m_ctrl[c];
      1: v = m_filt[c] | {st_full[c], st_empty[c], 1'b0, st_drop[c], 12'h0};
      2: v = m_pre[c];
      3: v = m_tst[c];
      4: v = st_count[c*16 +: 16];
      5: v = st_high[c*16 +: 16];
      default: v = st_low[c*16 +: 16];
    endcase
    return {16'h0, v};
  endfunction

  task automatic chk_outputs(input string req);
    logic [NC-1:0] e_en;
    logic [NC*3-1:0] e_clk, e_src, e_deb;
    logic [NC*2-1:0] e_mode;
    logic [NC*4-1:0] e_thr;
    logic [NC*16-1:0] e_pre, e_tst;
    for (int c = 0; c < NC; c++) begin
      e_en[c] = m_ctrl[c][0];
      e_src[c*3 +: 3] = m_ctrl[c][5:3];
      e_clk[c*3 +: 3] = m_ctrl[c][8:6];
      e_mode[c*2 +: 2] = m_filt[c][1:0];
      e_thr[c*4 +: 4] = m_filt[c][5:2];
      e_deb[c*3 +: 3] = m_filt[c][8:6];
      e_pre[c*16 +: 16] = m_pre[c];
      e_tst[c*16 +: 16] = m_tst[c];
    end
    chk({ch_en, ch_src_sel, ch_clk_sel, ch_edge_mode, ch_thresh, ch_debounce},
        {e_en, e_src, e_clk, e_mode, e_thr, e_deb}, {req, " fields"});
    chk({ch_prescale, ch_test_scale}, {e_pre, e_tst}, {req, " R7 scales"});
  endtask

  // write, then check strobes in the following cycle and the cycle after
  task automatic do_write(input int a, input logic [31:0] w, input string req);
    logic [NC-1:0] e_irq, e_fifo;
    e_irq = '0; e_fifo = '0;
    if (a < NC*7) begin
      if (a % 7 == 0 && w[18] && w[2])  e_irq[a/7]  = 1'b1;
      if (a % 7 == 1 && w[29] && w[13]) e_fifo[a/7] = 1'b1;
    end
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = AW'(a); bus_wdata = w;
    @(negedge clk);
    bus_wr = 1'b0;
    model_write(a, w);
    chk(irq_clr, e_irq, {req, " R4 irq pulse"});
    chk(fifo_clr, e_fifo, {req, " R5 fifo pulse"});
    chk_outputs(req);
    @(negedge clk);
    chk({irq_clr, fifo_clr}, '0, {req, " R4 R5 pulse width"});
  endtask

  task automatic do_read(input int a, input string req);
    logic [31:0] e;
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = AW'(a);
    e = exp_word(a);
    @(negedge clk);
    bus_rd = 1'b0;
    chk(bus_rdata, e, req);
  endtask

  task automatic rand_status();
    st_full = NC'($urandom); st_empty = NC'($urandom); st_drop = NC'($urandom);
    for (int c = 0; c < NC; c++) begin
      st_count[c*16 +: 16] = 16'($urandom);
      st_high[c*16 +: 16]  = 16'($urandom);
      st_low[c*16 +: 16]   = 16'($urandom);
    end
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_err++; n_chk++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] held;
    void'($urandom(32'd20240611));
    for (int c = 0; c < NC; c++) begin
      m_ctrl[c] = 0; m_filt[c] = 0; m_pre[c] = 0; m_tst[c] = 0;
    end
    rst = 1'b1; bus_wr = 0; bus_rd = 0; bus_addr = 0; bus_wdata = 0;
    rand_status();
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R3 reset state
    chk({bus_rdata, irq_clr, fifo_clr}, '0, "R3 reset rdata/strobes");
    chk_outputs("R3 reset");

    // R1 single-bit masked set
    do_write(0, 32'h0001_0001, "R1 set enable only");
    do_read(0, "R1 readback word0");
    // R1 no mask => no change
    do_write(0, 32'h0000_FFFF, "R1 zero mask");
    do_read(0, "R1 zero mask readback");
    // R4 interrupt clear on channel 2, neighbours quiet
    do_write(14, 32'h0004_0004, "R4 irq ch2");
    do_read(14, "R4 strobe bit reads zero");
    do_write(14, 32'h0000_0004, "R4 irq without mask");
    // R5 fifo clear: write zero, then write one
    do_write(8, 32'h2000_0000, "R5 fifo clr write zero");
    do_write(8, 32'h2000_2000, "R5 fifo clr ch1");
    do_write(22, 32'h0000_2000, "R5 fifo clr no mask");
    // R8 reserved bits ignore writes
    do_write(0, 32'hFE02_FE02, "R8 reserved word0");
    do_read(0, "R8 reserved word0 read");
    do_write(1, 32'h0E00_0E00, "R8 reserved word1");
    // R6 read-only status ignores writes
    st_full = 4'b1010; st_empty = 4'b0101; st_drop = 4'b1100;
    do_write(1 + 7*3, 32'hD000_D000, "R6 write status bits");
    do_read(1 + 7*3, "R6 status bits ch3");
    do_write(4, 32'hFFFF_FFFF, "R6 write count word");
    do_read(4, "R6 count word");
    do_read(5 + 7*2, "R6 high width ch2");
    do_read(6 + 7*1, "R6 low width ch1");
    // R7 scales
    do_write(2 + 7*3, 32'hFFFF_A5C3, "R7 prescale ch3");
    do_write(3, 32'h00F0_1234, "R7 test scale ch0 partial");
    do_read(3, "R7 test scale readback");
    // R9 unmapped region
    for (int a = NC*7; a < 32; a++) begin
      do_write(a, 32'hFFFF_FFFF, "R9 unmapped write");
      do_read(a, "R9 unmapped read");
    end
    // R8 channel layout at boundaries
    do_write(6, 32'hFFFF_FFFF, "R8 last word ch0");
    do_write(7, 32'h01F9_0149, "R8 first word ch1");
    do_read(7, "R8 first word ch1 read");
    // R10 rdata holds without a read
    held = bus_rdata;
    do_write(7, 32'h0001_0000, "R10 write between reads");
    repeat (3) @(negedge clk);
    chk(bus_rdata, held, "R10 rdata held");

    // random mix, R1 R2 R5 R4
    for (int i = 0; i < 600; i++) begin
      int a;
      logic [31:0] w;
      a = int'($urandom_range(31, 0));
      w = $urandom;
      if ($urandom_range(3, 0) == 0) rand_status();
      if ($urandom_range(1, 0) == 1)
        do_write(a, w, "R1 random write");
      else
        do_read(a, "R2 R1 random read");
    end

    // R3 reset again clears everything
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    for (int c = 0; c < NC; c++) begin
      m_ctrl[c] = 0; m_filt[c] = 0; m_pre[c] = 0; m_tst[c] = 0;
    end
    chk(bus_rdata, '0, "R3 re-reset rdata");
    chk_outputs("R3 re-reset");

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule